// File: doc/BRIEF.md
# Single and Paired Register Shift Unit

This block shifts an 8-bit register value, or a 16-bit value formed from a pair of registers, by 0 to 7 places in one combinational step. The caller picks the direction, the kind of shift (logical, arithmetic or rotate) and whether the single or the paired width applies. The result appears on the outputs in the same step.

In paired mode the even register supplies the upper half and the following odd register supplies the lower half. Bits cross between the halves as the pair shifts. The result comes back split into its even and odd halves. In single mode only the even operand is shifted, and the odd operand passes through untouched.

An arithmetic shift never changes the sign bit. It is bit 7 in single mode and bit 15 of the pair in paired mode. Right arithmetic shifts copy the sign bit into the vacated upper bits. Left arithmetic shifts fill the vacated low bits with zeros and leave the sign bit where it was.

Top module: `shift_unit`

## Requirements
- R1: Logical right shift (kind 2'b00, direction 1) moves each bit down by the amount and fills the vacated upper bits with 0. For example, 8'b1001_0110 shifted by 2 gives 8'b0010_0101.
- R2: Logical left shift (kind 2'b00, direction 0) moves each bit up by the amount and fills the vacated low bits with 0, which may change the sign bit. For example, 8'b1001_0110 shifted by 2 gives 8'b0101_1000.
- R3: Arithmetic right shift (kind 2'b01, direction 1) fills the vacated upper bits with copies of the sign bit.
- R4: Arithmetic left shift (kind 2'b01, direction 0) keeps the sign bit unchanged, shifts the bits below it up and fills the low bits with 0.
- R5: Rotate (kind 2'b10) loses no bits. A left rotate by N gives the same result as a right rotate by the operand width minus N.
- R6: With the pair select high, the operand is {even, odd}, with even as the upper 8 bits. The 16-bit result is returned with its upper half on the even output and its lower half on the odd output.
- R7: In paired mode the arithmetic sign bit is bit 15 of the pair, which is bit 7 of the even operand.
- R8: A shift amount of 0 returns the operand unchanged for every kind and direction.
- R9: With the pair select low, the odd result equals the odd operand.
- R10: Kind 2'b11 returns the operand (single or pair) unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pair_i | input | 1 | 1 = shift the 16-bit even/odd pair, 0 = shift the even operand alone |
| dir_i | input | 1 | 0 = left, 1 = right |
| kind_i | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 pass unchanged |
| amt_i | input | 3 | Shift distance, 0 to 7 |
| op_even_i | input | 8 | Even register operand (upper half of a pair) |
| op_odd_i | input | 8 | Odd register operand (lower half of a pair) |
| res_even_o | output | 8 | Shifted single result, or upper half of the shifted pair |
| res_odd_o | output | 8 | Lower half of the shifted pair, or the odd operand in single mode |

## Verification
The hardest case to reach from the ports is a paired shift where bits must cross the boundary between the two halves. The same case covers a paired arithmetic shift, whose sign comes from the even operand while the odd half only ever receives bits from above it or zeros. To reach it, the stimulus uses pairs whose halves differ clearly, with the even sign bit set in some and cleared in others. Every kind, direction and amount is swept over these pairs and compared with a bit-by-bit model, so that each distance from 1 to 7 moves known bits across the half boundary. Literal checks for the single-width examples and for rotate equivalence complete the coverage.

// File: rtl/shift_pkg.sv
package shift_pkg;

  typedef enum logic [1:0] {
    KIND_LOGIC  = 2'd0,
    KIND_ARITH  = 2'd1,
    KIND_ROTATE = 2'd2,
    KIND_HOLD   = 2'd3
  } shift_kind_e;

  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } shift_dir_e;

endpackage

// File: rtl/shift_stage.sv
// One level of a logarithmic right shifter: shifts by DIST when en_i is set.
module shift_stage
  import shift_pkg::*;
#(
  parameter int N    = 8,
  parameter int DIST = 1
) (
  input  logic        en_i,
  input  shift_kind_e fill_i,
  input  logic        sign_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i + DIST < N) begin : g_inside
      assign q_o[i] = en_i ? d_i[i+DIST] : d_i[i];
    end else begin : g_edge
      logic fill_bit;
      always_comb begin
        unique case (fill_i)
          KIND_ROTATE: fill_bit = d_i[i+DIST-N];
          KIND_ARITH:  fill_bit = sign_i;
          default:     fill_bit = 1'b0;
        endcase
      end
      assign q_o[i] = en_i ? fill_bit : d_i[i];
    end
  end

endmodule

// File: rtl/shift_core.sv
// N-bit barrel shifter. Left shifts reuse the right-shift stages on the bit-reversed operand.
module shift_core
  import shift_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 3
) (
  input  shift_dir_e   dir_i,
  input  shift_kind_e  kind_i,
  input  logic [AW-1:0] amt_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  logic        is_left;
  logic        sign_bit;
  shift_kind_e fill_kind;
  logic [N-1:0] d_rev;
  logic [N-1:0] pre;
  logic [N-1:0] post;
  logic [N-1:0] post_rev;
  logic [N-1:0] stg [AW+1];

  assign is_left  = (dir_i == DIR_LEFT);
  assign sign_bit = d_i[N-1];

  // left arithmetic vacates low bits, which take zeros
  assign fill_kind = (is_left && kind_i == KIND_ARITH) ? KIND_LOGIC : kind_i;

  for (genvar i = 0; i < N; i++) begin : g_rev
    assign d_rev[i]    = d_i[N-1-i];
    assign post_rev[i] = stg[AW][N-1-i];
  end

  assign pre    = is_left ? d_rev : d_i;
  assign stg[0] = pre;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    shift_stage #(
      .N   (N),
      .DIST(1 << s)
    ) u_stage (
      .en_i  (amt_i[s]),
      .fill_i(fill_kind),
      .sign_i(sign_bit),
      .d_i   (stg[s]),
      .q_o   (stg[s+1])
    );
  end

  assign post = is_left ? post_rev : stg[AW];

  always_comb begin
    if (kind_i == KIND_HOLD) begin
      q_o = d_i;
    end else if (is_left && kind_i == KIND_ARITH) begin
      q_o = {sign_bit, post[N-2:0]};
    end else begin
      q_o = post;
    end
  end

endmodule

// File: rtl/shift_unit.sv
// Single or paired register shift unit, combinational.
module shift_unit
  import shift_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                 pair_i,
  input  logic                 dir_i,
  input  logic [1:0]           kind_i,
  input  logic [$clog2(W)-1:0] amt_i,
  input  logic [W-1:0]         op_even_i,
  input  logic [W-1:0]         op_odd_i,
  output logic [W-1:0]         res_even_o,
  output logic [W-1:0]         res_odd_o
);

  localparam int PW = 2 * W;
  localparam int AW = $clog2(W);

  shift_dir_e  dir;
  shift_kind_e kind;
  logic [W-1:0]  single_q;
  logic [PW-1:0] pair_d;
  logic [PW-1:0] pair_q;

  assign dir    = shift_dir_e'(dir_i);
  assign kind   = shift_kind_e'(kind_i);
  assign pair_d = {op_even_i, op_odd_i};

  shift_core #(.N(W), .AW(AW)) u_single (
    .dir_i (dir),
    .kind_i(kind),
    .amt_i (amt_i),
    .d_i   (op_even_i),
    .q_o   (single_q)
  );

  shift_core #(.N(PW), .AW(AW)) u_pair (
    .dir_i (dir),
    .kind_i(kind),
    .amt_i (amt_i),
    .d_i   (pair_d),
    .q_o   (pair_q)
  );

  always_comb begin
    if (pair_i) begin
      res_even_o = pair_q[PW-1:W];
      res_odd_o  = pair_q[W-1:0];
    end else begin
      res_even_o = single_q;
      res_odd_o  = op_odd_i;
    end
  end

endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
  parameter int W = 8
) (
  input logic                 pair_i,
  input logic                 dir_i,
  input logic [1:0]           kind_i,
  input logic [$clog2(W)-1:0] amt_i,
  input logic [W-1:0]         op_even_i,
  input logic [W-1:0]         op_odd_i,
  input logic [W-1:0]         res_even_o,
  input logic [W-1:0]         res_odd_o
);

  always_comb begin
    p_amt0_pass_r8: assert (amt_i != '0 ||
                            (res_even_o == op_even_i && res_odd_o == op_odd_i));
    p_single_odd_hold_r9: assert (pair_i || res_odd_o == op_odd_i);
    p_hold_pass_r10: assert (kind_i != 2'd3 ||
                             (res_even_o == op_even_i && res_odd_o == op_odd_i));
    // R4, R7: sign bit (even bit W-1) survives any arithmetic shift
    p_arith_sign_keep_r4: assert (kind_i != 2'd1 ||
                                  res_even_o[W-1] == op_even_i[W-1]);
    p_rotate_bits_r5: assert (kind_i != 2'd2 ||
      ($countones({res_even_o, res_odd_o}) == $countones({op_even_i, op_odd_i})));
    p_lsr_fill_r1: assert (!(kind_i == 2'd0 && dir_i && amt_i != '0) ||
                           res_even_o[W-1] == 1'b0);
  end

endmodule

bind shift_unit shift_unit_chk #(.W(W)) u_chk (
  .pair_i    (pair_i),
  .dir_i     (dir_i),
  .kind_i    (kind_i),
  .amt_i     (amt_i),
  .op_even_i (op_even_i),
  .op_odd_i  (op_odd_i),
  .res_even_o(res_even_o),
  .res_odd_o (res_odd_o)
);

// File: tb/tb_shift_unit.sv
`timescale 1ns/1ps
module tb_shift_unit;

  logic       clk;
  logic       rst_n;
  logic       pair_i;
  logic       dir_i;
  logic [1:0] kind_i;
  logic [2:0] amt_i;
  logic [7:0] op_even_i;
  logic [7:0] op_odd_i;
  logic [7:0] res_even_o;
  logic [7:0] res_odd_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  shift_unit #(.W(8)) dut (
    .pair_i    (pair_i),
    .dir_i     (dir_i),
    .kind_i    (kind_i),
    .amt_i     (amt_i),
    .op_even_i (op_even_i),
    .op_odd_i  (op_odd_i),
    .res_even_o(res_even_o),
    .res_odd_o (res_odd_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] model(logic dbl, logic dir, logic [1:0] kind,
                                        int amt, logic [7:0] e, logic [7:0] o);
    logic [15:0] x;
    logic [15:0] y;
    int n;
    n = dbl ? 16 : 8;
    x = dbl ? {e, o} : {8'h00, e};
    y = x;
    if (kind != 2'd3) begin
      for (int i = 0; i < n; i++) begin
        int src;
        if (dir) begin
          src = i + amt;
          if (src < n)         y[i] = x[src];
          else if (kind == 2)  y[i] = x[src-n];
          else if (kind == 1)  y[i] = x[n-1];
          else                 y[i] = 1'b0;
        end else begin
          src = i - amt;
          if (src >= 0)        y[i] = x[src];
          else if (kind == 2)  y[i] = x[src+n];
          else                 y[i] = 1'b0;
        end
      end
      if (kind == 2'd1 && !dir) y[n-1] = x[n-1];
    end
    return dbl ? y : {y[7:0], o};
  endfunction

  task automatic apply(logic dbl, logic dir, logic [1:0] kind, int amt,
                       logic [7:0] e, logic [7:0] o);
    @(posedge clk);
    pair_i = dbl; dir_i = dir; kind_i = kind; amt_i = 3'(amt);
    op_even_i = e; op_odd_i = o;
    #1;
  endtask

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic t_reset_state();
    apply(0, 0, 2'd0, 0, 8'h00, 8'h00);
    check("R8 idle", {res_even_o, res_odd_o}, 16'h0000);
  endtask

  task automatic t_logical_examples();
    apply(0, 1, 2'd0, 2, 8'b1001_0110, 8'h3C);
    check("R1 lsr2", {res_even_o, res_odd_o}, {8'b0010_0101, 8'h3C});
    apply(0, 1, 2'd0, 1, 8'b1001_0110, 8'h3C);
    check("R1 lsr1", {res_even_o, res_odd_o}, {8'b0100_1011, 8'h3C});
    apply(0, 0, 2'd0, 2, 8'b1001_0110, 8'h3C);
    check("R2 lsl2", {res_even_o, res_odd_o}, {8'b0101_1000, 8'h3C});
    apply(0, 0, 2'd0, 1, 8'b1001_0110, 8'h3C);
    check("R2 lsl1 sign change", {res_even_o, res_odd_o}, {8'b0010_1100, 8'h3C});
  endtask

  task automatic t_arith();
    apply(0, 1, 2'd1, 3, 8'b1001_0110, 8'h00);
    check("R3 asr neg", {res_even_o, res_odd_o}, {8'b1111_0010, 8'h00});
    apply(0, 1, 2'd1, 3, 8'b0101_0110, 8'h00);
    check("R3 asr pos", {res_even_o, res_odd_o}, {8'b0000_1010, 8'h00});
    apply(0, 0, 2'd1, 1, 8'b0110_1000, 8'h00);
    check("R4 asl pos keeps 0", {res_even_o, res_odd_o}, {8'b0101_0000, 8'h00});
    apply(0, 0, 2'd1, 2, 8'b1001_0111, 8'h00);
    check("R4 asl neg keeps 1", {res_even_o, res_odd_o}, {8'b1101_1100, 8'h00});
  endtask

  task automatic t_rotate();
    logic [7:0] lft;
    apply(0, 0, 2'd2, 3, 8'b1001_0110, 8'h00);
    check("R5 rol3", {res_even_o, res_odd_o}, {8'b1011_0100, 8'h00});
    for (int k = 1; k < 8; k++) begin
      apply(0, 0, 2'd2, k, 8'hC5, 8'h00);
      lft = res_even_o;
      apply(0, 1, 2'd2, 8 - k, 8'hC5, 8'h00);
      check("R5 rol n == ror w-n", {8'h00, res_even_o}, {8'h00, lft});
    end
  endtask

  task automatic t_pair();
    apply(1, 1, 2'd0, 4, 8'hA5, 8'h3C);
    check("R6 pair lsr4", {res_even_o, res_odd_o}, 16'h0A53);
    apply(1, 0, 2'd0, 4, 8'hA5, 8'h3C);
    check("R6 pair lsl4", {res_even_o, res_odd_o}, 16'h53C0);
    apply(1, 1, 2'd1, 5, 8'h81, 8'h00);
    check("R7 pair asr sign15", {res_even_o, res_odd_o}, 16'hFC08);
    apply(1, 0, 2'd1, 7, 8'h80, 8'hFF);
    check("R7 pair asl sign15", {res_even_o, res_odd_o}, 16'hFF80);
    apply(1, 0, 2'd2, 7, 8'h01, 8'h80);
    check("R6 pair rol7", {res_even_o, res_odd_o}, 16'hC000);
  endtask

  task automatic t_zero_amt();
    for (int k = 0; k < 4; k++) begin
      for (int d = 0; d < 2; d++) begin
        apply(k[0], d[0], 2'(k), 0, 8'h96, 8'h5A);
        check("R8 amt0", {res_even_o, res_odd_o}, 16'h965A);
      end
    end
  endtask

  task automatic t_single_odd();
    apply(0, 1, 2'd2, 5, 8'h12, 8'hE7);
    check("R9 odd untouched", {8'h00, res_odd_o}, 16'h00E7);
  endtask

  task automatic t_hold();
    apply(1, 1, 2'd3, 6, 8'hB4, 8'h69);
    check("R10 hold pair", {res_even_o, res_odd_o}, 16'hB469);
    apply(0, 0, 2'd3, 3, 8'hB4, 8'h69);
    check("R10 hold single", {res_even_o, res_odd_o}, 16'hB469);
  endtask

  task automatic t_sweep();
    logic [7:0] ev [4] = '{8'h96, 8'h5A, 8'h81, 8'h7E};
    logic [7:0] od [4] = '{8'h3C, 8'hC3, 8'h01, 8'hF0};
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 2; m++)
        for (int d = 0; d < 2; d++)
          for (int k = 0; k < 4; k++)
            for (int a = 0; a < 8; a++) begin
              apply(m[0], d[0], 2'(k), a, ev[p], od[p]);
              check(m[0] ? "R6 R7 pair sweep" : "R1 R3 R5 single sweep",
                    {res_even_o, res_odd_o},
                    model(m[0], d[0], 2'(k), a, ev[p], od[p]));
            end
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pair_i = 0; dir_i = 0; kind_i = 0; amt_i = 0; op_even_i = 0; op_odd_i = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_logical_examples();
    t_arith();
    t_rotate();
    t_pair();
    t_zero_amt();
    t_single_odd();
    t_hold();
    t_sweep();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule